// File: doc/BRIEF.md
# DMA transfer mode selector

This block picks the fastest DMA transfer mode that both an attached drive and its host controller can run, and never exceeds a mode requested by the caller. It looks at the drive's identify information: two validity flags, the UltraDMA, multiword and single-word support words, and an older single-word timing field. It also looks at the host's per-family capability masks, a cable-detect input, a media type flag and a policy flag that forbids DMA on non-disk devices.

A one-cycle `start` pulse samples all inputs. One cycle later `done` pulses and `mode_out` carries an 8-bit mode code, where 0 means "no DMA". The three families use fixed code bases: 0x40 for UltraDMA mode 0, 0x20 for multiword mode 0 and 0x10 for single-word mode 0. Mode n of a family is its base plus n. Alongside the mode, `id_err` reports identify data in which two families both claim a currently active mode. Both outputs hold their values until the next `start`.

Top module: `dma_mode_sel`

## Requirements
- R1: Every `start` sampled at a rising edge produces `done` high for exactly the following cycle. `mode_out` and `id_err` change only on that cycle and hold otherwise. After reset all three outputs are 0.
- R2: Families are searched in the order UltraDMA, multiword, single-word. A family whose base code (0x40, 0x20, 0x10) is greater than `req_mode` is skipped, and the search moves on to the next family.
- R3: The first eligible family with a nonzero mask wins. The mode is that family's base plus the index of the highest set bit of its mask. If no family qualifies, the mode is 0.
- R4: The UltraDMA mask is `host_udma_mask` AND `udma_word[7:0]`. It is nonzero only when `udma_valid` is 1.
- R5: The UltraDMA mask is reduced to bits 0..2 when all of the following hold: `req_mode` is above 0x42, the mask has any of bits 3..6 set, and `cable_80w` is 0.
- R6: The multiword mask is `host_mwdma_mask` AND `mwdma_word[7:0]`. It is nonzero only when `dma_valid` is 1.
- R7: When `dma_valid` is 1, the single-word mask is `host_swdma_mask` AND `swdma_word[7:0]`. Otherwise, if `legacy_sw_timing` is nonzero and its low byte m is at most 2, the mask is ((2<<m)-1) AND `host_swdma_mask`. In every other case it is 0.
- R8: When `media_disk` is 0 and `no_atapi_dma` is 1, the mode is 0 whatever the other inputs are.
- R9: The reported mode is the smaller of the selected mode and `req_mode`.
- R10: If `udma_valid` is 1, `id_err` is set when both `udma_word[15:8]` and `mwdma_word[15:8]` are nonzero. If `udma_valid` is 0 and `dma_valid` is 1, `id_err` is set when both `mwdma_word[15:8]` and `swdma_word[15:8]` are nonzero. Otherwise `id_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample inputs and compute a mode |
| req_mode | input | 8 | Upper bound on the reported mode code |
| udma_valid | input | 1 | Identify UltraDMA word is valid |
| dma_valid | input | 1 | Identify multiword and single-word words are valid |
| udma_word | input | WORD_W | Drive UltraDMA word: supported modes in the low byte, active mode in the high byte |
| mwdma_word | input | WORD_W | Drive multiword word, same layout |
| swdma_word | input | WORD_W | Drive single-word word, same layout |
| legacy_sw_timing | input | WORD_W | Older single-word timing field; its low byte is the mode |
| host_udma_mask | input | 8 | Host UltraDMA capability mask |
| host_mwdma_mask | input | 8 | Host multiword capability mask |
| host_swdma_mask | input | 8 | Host single-word capability mask |
| cable_80w | input | 1 | 80-wire cable detected |
| media_disk | input | 1 | Device is a disk |
| no_atapi_dma | input | 1 | Forbid DMA on non-disk devices |
| done | output | 1 | One-cycle result strobe |
| mode_out | output | 8 | Selected mode code, 0 for no DMA |
| id_err | output | 1 | Identify data claims two active families |

## Verification
The hardest case to reach from the ports is the interaction of the cable clamp with family fall-through and the final cap. A clamped UltraDMA mask must still win over multiword. The requested mode must sit just above 0x42 for the clamp to apply, and the cap must then bite on the clamped result. The stimulus sweeps a list of requested modes that straddles every family base and the 0x42 clamp threshold. For each one it crosses all validity-flag combinations, both cable states and four identify/host patterns with media policy folded in. A reference model in the bench, written with different loop structure, supplies every expected value.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int MASK_W  = 8;
  localparam int CODE_W  = 8;
  localparam int IDX_W   = $clog2(MASK_W);
  localparam int NUM_FAM = 3;
  localparam int SLOW_TOP = 2;  // highest UltraDMA bit usable on a 40-wire cable
  localparam int FAST_TOP = 6;  // highest UltraDMA bit subject to the cable clamp

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MASK_W-1:0] mask_t;

  localparam code_t UDMA_BASE = 8'h40;
  localparam code_t MW_BASE   = 8'h20;
  localparam code_t SW_BASE   = 8'h10;
  localparam code_t CLAMP_REQ = UDMA_BASE + code_t'(SLOW_TOP);

  // Search order: index 0 is tried first.
  function automatic code_t fam_base(input int f);
    case (f)
      0:       return UDMA_BASE;
      1:       return MW_BASE;
      default: return SW_BASE;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] top_bit(input mask_t m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic mask_t slow_bits();
    mask_t r;
    r = '0;
    for (int i = 0; i <= SLOW_TOP; i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic mask_t fast_bits();
    mask_t r;
    r = '0;
    for (int i = SLOW_TOP + 1; i <= FAST_TOP; i++) r[i] = 1'b1;
    return r;
  endfunction

  // All modes up to and including m.
  function automatic mask_t legacy_mask(input logic [7:0] m);
    mask_t r;
    r = '0;
    for (int i = 0; i < MASK_W; i++)
      if (8'(i) <= m) r[i] = 1'b1;
    return r;
  endfunction

  function automatic code_t min_code(input code_t a, input code_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/dms_fam_mask.sv
module dms_fam_mask
  import dms_pkg::*;
(
  input  logic  fam_ok,
  input  mask_t drv_mask,
  input  mask_t host_mask,
  input  logic  alt_ok,
  input  mask_t alt_mask,
  input  logic  clamp_on,
  output mask_t mask,
  output logic  clamp_hit
);
  mask_t raw;

  always_comb begin
    if (fam_ok)      raw = host_mask & drv_mask;
    else if (alt_ok) raw = host_mask & alt_mask;
    else             raw = '0;
  end

  assign clamp_hit = clamp_on && ((raw & fast_bits()) != '0);
  assign mask      = clamp_hit ? (raw & slow_bits()) : raw;
endmodule

// File: rtl/dms_pick.sv
module dms_pick
  import dms_pkg::*;
(
  input  mask_t [NUM_FAM-1:0] masks,
  input  code_t               req_mode,
  output code_t               pick_code,
  output logic                pick_hit
);
  always_comb begin
    pick_code = '0;
    pick_hit  = 1'b0;
    for (int f = 0; f < NUM_FAM; f++) begin
      if (!pick_hit && (req_mode >= fam_base(f)) && (masks[f] != '0)) begin
        pick_hit  = 1'b1;
        pick_code = fam_base(f) + code_t'(top_bit(masks[f]));
      end
    end
  end
endmodule

// File: rtl/dms_id_check.sv
module dms_id_check (
  input  logic       udma_valid,
  input  logic       dma_valid,
  input  logic [7:0] udma_act,
  input  logic [7:0] mw_act,
  input  logic [7:0] sw_act,
  output logic       id_bad
);
  always_comb begin
    if (udma_valid)     id_bad = (udma_act != 8'h00) && (mw_act != 8'h00);
    else if (dma_valid) id_bad = (mw_act != 8'h00) && (sw_act != 8'h00);
    else                id_bad = 1'b0;
  end
endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
  import dms_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        req_mode,
  input  logic              udma_valid,
  input  logic              dma_valid,
  input  logic [WORD_W-1:0] udma_word,
  input  logic [WORD_W-1:0] mwdma_word,
  input  logic [WORD_W-1:0] swdma_word,
  input  logic [WORD_W-1:0] legacy_sw_timing,
  input  logic [7:0]        host_udma_mask,
  input  logic [7:0]        host_mwdma_mask,
  input  logic [7:0]        host_swdma_mask,
  input  logic              cable_80w,
  input  logic              media_disk,
  input  logic              no_atapi_dma,
  output logic              done,
  output logic [7:0]        mode_out,
  output logic              id_err
);
  localparam int ACT_LO = 8;

  mask_t [NUM_FAM-1:0] fam_mask;
  logic  [NUM_FAM-1:0] fam_clamp;
  logic  legacy_ok;
  logic  atapi_block;
  logic  udma_clamp;
  code_t pick_code;
  logic  pick_hit;
  code_t final_code;
  logic  id_bad;

  assign legacy_ok  = (legacy_sw_timing != '0) && (legacy_sw_timing[7:0] <= 8'd2);
  assign udma_clamp = fam_clamp[0];

  for (genvar g = 0; g < NUM_FAM; g++) begin : g_fam
    logic  f_ok, f_alt_ok, f_clamp_on;
    mask_t f_drv, f_host, f_alt;
    if (g == 0) begin : g_udma
      assign f_ok       = udma_valid;
      assign f_drv      = udma_word[MASK_W-1:0];
      assign f_host     = host_udma_mask;
      assign f_alt_ok   = 1'b0;
      assign f_alt      = '0;
      assign f_clamp_on = (req_mode > CLAMP_REQ) && !cable_80w;
    end else if (g == 1) begin : g_mw
      assign f_ok       = dma_valid;
      assign f_drv      = mwdma_word[MASK_W-1:0];
      assign f_host     = host_mwdma_mask;
      assign f_alt_ok   = 1'b0;
      assign f_alt      = '0;
      assign f_clamp_on = 1'b0;
    end else begin : g_sw
      assign f_ok       = dma_valid;
      assign f_drv      = swdma_word[MASK_W-1:0];
      assign f_host     = host_swdma_mask;
      assign f_alt_ok   = legacy_ok;
      assign f_alt      = legacy_mask(legacy_sw_timing[7:0]);
      assign f_clamp_on = 1'b0;
    end

    dms_fam_mask i_mask (
      .fam_ok    (f_ok),
      .drv_mask  (f_drv),
      .host_mask (f_host),
      .alt_ok    (f_alt_ok),
      .alt_mask  (f_alt),
      .clamp_on  (f_clamp_on),
      .mask      (fam_mask[g]),
      .clamp_hit (fam_clamp[g])
    );
  end

  dms_pick i_pick (
    .masks     (fam_mask),
    .req_mode  (req_mode),
    .pick_code (pick_code),
    .pick_hit  (pick_hit)
  );

  dms_id_check i_idchk (
    .udma_valid (udma_valid),
    .dma_valid  (dma_valid),
    .udma_act   (udma_word[WORD_W-1:ACT_LO]),
    .mw_act     (mwdma_word[WORD_W-1:ACT_LO]),
    .sw_act     (swdma_word[WORD_W-1:ACT_LO]),
    .id_bad     (id_bad)
  );

  assign atapi_block = !media_disk && no_atapi_dma;
  assign final_code  = (atapi_block || !pick_hit) ? '0 : min_code(pick_code, req_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      mode_out <= '0;
      id_err   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        mode_out <= final_code;
        id_err   <= id_bad;
      end
    end
  end
endmodule

// File: rtl/dms_checker.sv
module dms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] req_mode,
  input logic       cable_80w,
  input logic       atapi_block,
  input logic       done,
  input logic [7:0] mode_out,
  input logic       id_err
);
  assert_done_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_done_needs_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  assert_outputs_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(mode_out) && $stable(id_err)));

  assert_cable_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(!cable_80w)) |-> !(mode_out > 8'h42 && mode_out < 8'h47));

  assert_policy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(atapi_block)) |-> (mode_out == 8'h00));

  assert_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mode_out <= $past(req_mode)));
endmodule

bind dma_mode_sel dms_checker i_dms_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .req_mode    (req_mode),
  .cable_80w   (cable_80w),
  .atapi_block (atapi_block),
  .done        (done),
  .mode_out    (mode_out),
  .id_err      (id_err)
);

// File: tb/test_dma_mode_sel.sv
module test_dma_mode_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  req = 8'h00;
  logic        uv = 1'b0, dv = 1'b0;
  logic [15:0] uw = '0, mw = '0, sw = '0, td = '0;
  logic [7:0]  hu = '0, hm = '0, hs = '0;
  logic        cab = 1'b0, disk = 1'b1, noat = 1'b0;
  logic        done, id_err;
  logic [7:0]  mode_out;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_mode_sel i_dma_mode_sel (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mode(req),
    .udma_valid(uv), .dma_valid(dv), .udma_word(uw), .mwdma_word(mw),
    .swdma_word(sw), .legacy_sw_timing(td), .host_udma_mask(hu),
    .host_mwdma_mask(hm), .host_swdma_mask(hs), .cable_80w(cab),
    .media_disk(disk), .no_atapi_dma(noat), .done(done),
    .mode_out(mode_out), .id_err(id_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hi_idx(input logic [7:0] m);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 8; i++) if (m[i]) r = 8'(i);
    return r;
  endfunction

  function automatic logic [7:0] ref_mode();
    logic [7:0] um, mm, sm, best;
    um = uv ? (hu & uw[7:0]) : 8'h00;
    if (req > 8'h42 && (um & 8'h78) != 8'h00 && !cab) um = um & 8'h07;
    mm = dv ? (hm & mw[7:0]) : 8'h00;
    sm = 8'h00;
    if (dv) sm = hs & sw[7:0];
    else if (td != 16'h0 && td[7:0] <= 8'd2)
      for (int i = 0; i <= int'(td[7:0]); i++) sm[i] = hs[i];
    best = 8'h00;
    if (req >= 8'h40 && um != 8'h00)      best = 8'h40 + hi_idx(um);
    else if (req >= 8'h20 && mm != 8'h00) best = 8'h20 + hi_idx(mm);
    else if (req >= 8'h10 && sm != 8'h00) best = 8'h10 + hi_idx(sm);
    if (!disk && noat) best = 8'h00;
    if (best > req) best = req;
    return best;
  endfunction

  function automatic logic ref_err();
    if (uv) return (uw[15:8] != 8'h0) && (mw[15:8] != 8'h0);
    if (dv) return (mw[15:8] != 8'h0) && (sw[15:8] != 8'h0);
    return 1'b0;
  endfunction

  task automatic run();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic setp(input int p);
    case (p)
      0: begin uw=16'h003f; mw=16'h0007; sw=16'h0007; td=16'h0000; hu=8'hff; hm=8'h07; hs=8'h07; disk=1; noat=0; end
      1: begin uw=16'h0407; mw=16'h0403; sw=16'h0401; td=16'h0002; hu=8'h7f; hm=8'h05; hs=8'h03; disk=0; noat=1; end
      2: begin uw=16'h0078; mw=16'h0000; sw=16'h0402; td=16'h0001; hu=8'h18; hm=8'hff; hs=8'hff; disk=0; noat=0; end
      default: begin uw=16'h00ff; mw=16'h0404; sw=16'h0000; td=16'h0005; hu=8'h0f; hm=8'h04; hs=8'h01; disk=1; noat=1; end
    endcase
  endtask

  task automatic base_cfg();
    uv=1; dv=1; uw=16'h003f; mw=16'h0007; sw=16'h0007; td=16'h0;
    hu=8'h3f; hm=8'h07; hs=8'h07; cab=1; disk=1; noat=0; req=8'hff;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] reqs [14] = '{8'h00, 8'h0f, 8'h10, 8'h12, 8'h1f, 8'h20, 8'h21,
                              8'h3f, 8'h40, 8'h42, 8'h43, 8'h45, 8'h47, 8'hff};
    repeat (3) @(negedge clk);
    chk("R1 reset done", {7'b0, done}, 8'h00);
    chk("R1 reset mode", mode_out, 8'h00);
    chk("R1 reset err", {7'b0, id_err}, 8'h00);
    rst_n = 1'b1;

    // R3: best UltraDMA bit
    base_cfg(); run();
    chk("R1 done pulse", {7'b0, done}, 8'h01);
    chk("R3 udma top bit", mode_out, 8'h45);
    @(negedge clk);
    chk("R1 done single cycle", {7'b0, done}, 8'h00);
    uw = 16'h0001; @(negedge clk);
    chk("R1 mode held without start", mode_out, 8'h45);

    // R2: request below UltraDMA base falls to multiword
    base_cfg(); req = 8'h22; run(); chk("R2 skip udma", mode_out, 8'h22);
    base_cfg(); req = 8'h1f; run(); chk("R2 skip to single-word", mode_out, 8'h12);
    base_cfg(); hm = 8'h00; req = 8'h3f; run(); chk("R2 empty mw falls through", mode_out, 8'h12);

    // R4: UltraDMA gated by its validity flag
    base_cfg(); uv = 0; run(); chk("R4 udma invalid", mode_out, 8'h22);
    base_cfg(); hu = 8'h05; run(); chk("R4 host and drive", mode_out, 8'h42);

    // R5: cable clamp
    base_cfg(); cab = 0; req = 8'h45; run(); chk("R5 clamp 40-wire", mode_out, 8'h42);
    base_cfg(); cab = 1; req = 8'h45; run(); chk("R5 no clamp 80-wire", mode_out, 8'h45);
    base_cfg(); cab = 0; req = 8'h42; run(); chk("R5 low request no clamp", mode_out, 8'h42);
    base_cfg(); cab = 0; uw = 16'h0078; req = 8'hff; run(); chk("R5 clamp empties udma", mode_out, 8'h22);

    // R6: multiword
    base_cfg(); uv = 0; mw = 16'h0003; run(); chk("R6 mw mask", mode_out, 8'h21);
    base_cfg(); uv = 0; dv = 0; td = 16'h0; run(); chk("R6 mw invalid", mode_out, 8'h00);

    // R7: single-word and legacy timing
    base_cfg(); uv = 0; hm = 0; sw = 16'h0002; run(); chk("R7 sw word", mode_out, 8'h11);
    base_cfg(); uv = 0; dv = 0; td = 16'h0001; run(); chk("R7 legacy m1", mode_out, 8'h11);
    base_cfg(); uv = 0; dv = 0; td = 16'h0003; run(); chk("R7 legacy too large", mode_out, 8'h00);
    base_cfg(); uv = 0; dv = 0; td = 16'h0100; run(); chk("R7 legacy m0", mode_out, 8'h10);
    base_cfg(); uv = 0; dv = 0; td = 16'h0002; hs = 8'h03; run(); chk("R7 legacy host mask", mode_out, 8'h11);

    // R8: policy
    base_cfg(); disk = 0; noat = 1; run(); chk("R8 non-disk blocked", mode_out, 8'h00);
    base_cfg(); disk = 0; noat = 0; run(); chk("R8 non-disk allowed", mode_out, 8'h45);
    base_cfg(); disk = 1; noat = 1; run(); chk("R8 disk unaffected", mode_out, 8'h45);

    // R9: cap at request
    base_cfg(); req = 8'h41; run(); chk("R9 cap", mode_out, 8'h41);
    base_cfg(); req = 8'h05; run(); chk("R9 below all bases", mode_out, 8'h00);

    // R10: identify consistency
    base_cfg(); uw = 16'h043f; mw = 16'h0407; run(); chk("R10 udma+mw", {7'b0, id_err}, 8'h01);
    base_cfg(); uv = 0; mw = 16'h0407; sw = 16'h0207; run(); chk("R10 mw+sw", {7'b0, id_err}, 8'h01);
    base_cfg(); mw = 16'h0407; sw = 16'h0207; run(); chk("R10 udma flag wins", {7'b0, id_err}, 8'h00);
    base_cfg(); uv = 0; dv = 0; mw = 16'h0407; sw = 16'h0207; run(); chk("R10 no flags", {7'b0, id_err}, 8'h00);

    // R3 sweep over requests, flags, cable and patterns
    foreach (reqs[k]) begin
      for (int v = 0; v < 4; v++) begin
        for (int c = 0; c < 2; c++) begin
          for (int p = 0; p < 4; p++) begin
            setp(p); req = reqs[k]; uv = v[1]; dv = v[0]; cab = c[0];
            run();
            chk($sformatf("R3 sweep req=%h v=%0d c=%0d p=%0d", req, v, c, p), mode_out, ref_mode());
            chk("R10 sweep", {7'b0, id_err}, {7'b0, ref_err()});
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule